// File: doc/BRIEF.md
# Clock-Throttling Power Management Controller

This block sits next to a small microcontroller core and tells external clock-control logic how to clock that core. It drives two indicators: a stop request, which asks for the core clock to be halted completely, and a slow request, which asks for a reduced core clock frequency. The clock generator, gating cells and divider live outside; this block only decides which indicator is active.

Software sets the low-power state through a single control register on a special-function-register style bus: one write strobe, one fixed address, and a combinational read path. Two independent switchback enables let serial-port activity or a pending interrupt temporarily pull the core back to full speed. The slow request drops while such activity is present and comes back automatically once it ends, provided the slow-mode bit is still set. Any pending interrupt wakes the core from stop mode. It removes the stop request in the same cycle and clears the stop bit at the next clock edge.

Top module: `pmc_clk_throttle`

## Requirements
- R1: After reset every control bit is 0, `clk_stop` and `clk_slow` are 0, and a read of the control address returns 0.
- R2: A write (`sfr_we`=1) with `sfr_addr`=CTRL_ADDR (default 8'h87) loads the control bits at the next rising clock edge. The bit positions are: bit 0 slow mode, bit 1 stop, bit 2 serial switchback enable, bit 3 interrupt switchback enable. Bits 7..4 of the write data are ignored.
- R3: A write to any address other than CTRL_ADDR leaves every control bit unchanged.
- R4: `sfr_rdata` equals the four control bits, zero-extended, whenever `sfr_addr`=CTRL_ADDR, and 0 for any other address, in the same cycle.
- R5: `clk_stop` is 1 exactly when the stop bit is set and no bit of `irq_pend` is set. A pending interrupt removes `clk_stop` in the same cycle.
- R6: Any set bit of `irq_pend` clears the stop bit at the next clock edge. This takes priority over a write that sets the stop bit in that same cycle.
- R7: While the serial switchback enable is set and any bit of `ser_busy` is 1, `clk_slow` is 0.
- R8: While the interrupt switchback enable is set and any bit of `irq_pend` is 1, `clk_slow` is 0.
- R9: `clk_slow` is 1 whenever the slow bit is set and neither R7 nor R8 applies. Switchback never changes the slow bit, so the slow request comes back in the first cycle without activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | ADDR_W (8) | Register bus address |
| sfr_wdata | input | DATA_W (8) | Register bus write data |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_rdata | output | DATA_W (8) | Register bus read data |
| irq_pend | input | NIRQ (4) | Pending, already-enabled interrupt requests |
| ser_busy | input | NSER (2) | Serial-port activity flags |
| clk_stop | output | 1 | Request to halt the core clock |
| clk_slow | output | 1 | Request for the reduced core clock |

## Verification
Random cycles mix register writes, some to the control address and some to other addresses, with sparse interrupt pulses and denser serial activity. This exercises every combination of mode and enable bits against the two activity sources. It separates serial-triggered switchback from interrupt-triggered switchback, and it separates stop wake-up from slow-mode suppression. Directed cases cover the following:
- a stop-setting write that lands in the same cycle as an interrupt, which tells a correct priority apart from last-writer-wins;
- a write carrying high data bits, which shows whether the upper bits are masked;
- a write to a foreign address;
- a switchback episode with readback, which shows whether the slow bit survives.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int CTRL_W = 4;

   // bit 3: irq switchback enable, bit 2: serial switchback enable,
   // bit 1: stop request, bit 0: slow-clock mode
   typedef struct packed {
      logic irq_swb;
      logic ser_swb;
      logic stop;
      logic slow;
   } pmc_ctrl_t;
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
   import pmc_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h87
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   input  logic              stop_clr,
   output pmc_ctrl_t         ctrl,
   output logic [DATA_W-1:0] rdata
);
   localparam int PAD_W = DATA_W - CTRL_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("pmc_ctrl_reg: DATA_W must exceed the control width");
   end

   logic      hit;
   pmc_ctrl_t ctrl_nxt;

   assign hit = (addr == CTRL_ADDR);

   always_comb begin
      ctrl_nxt = ctrl;
      if (we && hit) begin
         ctrl_nxt = pmc_ctrl_t'(wdata[CTRL_W-1:0]);
      end
      if (stop_clr) begin
         ctrl_nxt.stop = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         ctrl <= ctrl_nxt;
      end
   end

   assign rdata = hit ? {{PAD_W{1'b0}}, ctrl} : '0;
endmodule

// File: rtl/pmc_boost.sv
module pmc_boost #(
   parameter int N = 2
) (
   input  logic [N-1:0] act,
   input  logic         en,
   output logic         boost
);
   if (N < 1) begin : g_bad_n
      $error("pmc_boost: at least one activity source is needed");
   end

   if (N == 1) begin : g_single
      assign boost = en & act[0];
   end else begin : g_multi
      logic [N-1:0] seen;
      assign seen[0] = act[0];
      for (genvar i = 1; i < N; i++) begin : g_chain
         assign seen[i] = seen[i-1] | act[i];
      end
      assign boost = en & seen[N-1];
   end
endmodule

// File: rtl/pmc_clk_throttle.sv
module pmc_clk_throttle
   import pmc_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h87,
   parameter int                NIRQ      = 4,
   parameter int                NSER      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic [DATA_W-1:0] sfr_wdata,
   input  logic              sfr_we,
   output logic [DATA_W-1:0] sfr_rdata,
   input  logic [NIRQ-1:0]   irq_pend,
   input  logic [NSER-1:0]   ser_busy,
   output logic              clk_stop,
   output logic              clk_slow
);
   pmc_ctrl_t ctrl_q;
   logic      irq_any;
   logic      ser_boost;
   logic      irq_boost;

   assign irq_any = |irq_pend;

   pmc_ctrl_reg #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CTRL_ADDR (CTRL_ADDR)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (sfr_addr),
      .wdata    (sfr_wdata),
      .we       (sfr_we),
      .stop_clr (irq_any),
      .ctrl     (ctrl_q),
      .rdata    (sfr_rdata)
   );

   pmc_boost #(.N(NSER)) u_ser_boost (
      .act   (ser_busy),
      .en    (ctrl_q.ser_swb),
      .boost (ser_boost)
   );

   pmc_boost #(.N(NIRQ)) u_irq_boost (
      .act   (irq_pend),
      .en    (ctrl_q.irq_swb),
      .boost (irq_boost)
   );

   assign clk_stop = ctrl_q.stop & ~irq_any;
   assign clk_slow = ctrl_q.slow & ~ser_boost & ~irq_boost;
endmodule

// File: rtl/pmc_clk_throttle_chk.sv
module pmc_clk_throttle_chk #(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h87,
   parameter int                NIRQ      = 4,
   parameter int                NSER      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sfr_addr,
   input logic              sfr_we,
   input logic [NIRQ-1:0]   irq_pend,
   input logic [NSER-1:0]   ser_busy,
   input logic [3:0]        ctrl_bits,
   input logic              clk_stop,
   input logic              clk_slow
);
   p_wake_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_pend) |-> !clk_stop);

   p_stop_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_pend) |=> !ctrl_bits[1]);

   p_ser_switchback_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits[2] && (|ser_busy)) |-> !clk_slow);

   p_irq_switchback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits[3] && (|irq_pend)) |-> !clk_slow);

   p_foreign_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_we && sfr_addr != CTRL_ADDR && !(|irq_pend)) |=> $stable(ctrl_bits));

   p_slow_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(sfr_we && sfr_addr == CTRL_ADDR) |=> $stable(ctrl_bits[0]));
endmodule

bind pmc_clk_throttle pmc_clk_throttle_chk #(
   .ADDR_W    (ADDR_W),
   .CTRL_ADDR (CTRL_ADDR),
   .NIRQ      (NIRQ),
   .NSER      (NSER)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sfr_addr  (sfr_addr),
   .sfr_we    (sfr_we),
   .irq_pend  (irq_pend),
   .ser_busy  (ser_busy),
   .ctrl_bits (ctrl_q),
   .clk_stop  (clk_stop),
   .clk_slow  (clk_slow)
);

// File: tb/pmc_clk_throttle_tb.sv
module pmc_clk_throttle_tb;
   localparam logic [7:0] CA = 8'h87;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = '0;
   logic [7:0] sfr_wdata = '0;
   logic       sfr_we = 1'b0;
   logic [7:0] sfr_rdata;
   logic [3:0] irq_pend = '0;
   logic [1:0] ser_busy = '0;
   logic       clk_stop;
   logic       clk_slow;

   int   n_chk = 0;
   int   n_fail = 0;
   logic [3:0] m = '0;

   always #5 clk = ~clk;

   pmc_clk_throttle u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sfr_addr  (sfr_addr),
      .sfr_wdata (sfr_wdata),
      .sfr_we    (sfr_we),
      .sfr_rdata (sfr_rdata),
      .irq_pend  (irq_pend),
      .ser_busy  (ser_busy),
      .clk_stop  (clk_stop),
      .clk_slow  (clk_slow)
   );

   function automatic logic f_stop(logic [3:0] c, logic [3:0] irq);
      return c[1] & ~(|irq);
   endfunction

   function automatic logic f_slow(logic [3:0] c, logic [3:0] irq, logic [1:0] ser);
      return c[0] & ~(c[2] & (|ser)) & ~(c[3] & (|irq));
   endfunction

   function automatic logic [7:0] f_rd(logic [3:0] c, logic [7:0] a);
      return (a == CA) ? {4'b0, c} : 8'h00;
   endfunction

   task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive at negedge, compare combinational outputs, then advance model
   task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic [3:0] irq, input logic [1:0] ser, input string tag);
      @(negedge clk);
      sfr_we = we; sfr_addr = a; sfr_wdata = d; irq_pend = irq; ser_busy = ser;
      #1;
      check(clk_stop == f_stop(m, irq), {tag, " R5 stop"}, {7'b0, clk_stop}, {7'b0, f_stop(m, irq)});
      check(clk_slow == f_slow(m, irq, ser), {tag, " R7 R8 R9 slow"}, {7'b0, clk_slow},
            {7'b0, f_slow(m, irq, ser)});
      check(sfr_rdata == f_rd(m, a), {tag, " R4 read"}, sfr_rdata, f_rd(m, a));
      if (we && a == CA) m = d[3:0];
      if (|irq) m[1] = 1'b0;
   endtask

   task automatic readback(input logic [3:0] exp, input string req);
      @(negedge clk);
      sfr_we = 1'b0; sfr_addr = CA; irq_pend = '0; ser_busy = '0;
      #1;
      check(sfr_rdata == {4'b0, exp}, req, sfr_rdata, {4'b0, exp});
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      // R1 reset state
      #22;
      sfr_addr = CA;
      #1;
      check(clk_stop == 1'b0, "R1 stop", {7'b0, clk_stop}, 8'h0);
      check(clk_slow == 1'b0, "R1 slow", {7'b0, clk_slow}, 8'h0);
      check(sfr_rdata == 8'h00, "R1 read", sfr_rdata, 8'h00);
      rst_n = 1'b1;

      // R2 upper data bits ignored
      step(1'b1, CA, 8'hF1, 4'h0, 2'b00, "R2");
      readback(4'h1, "R2 mask");
      // R3 foreign address write
      step(1'b1, 8'h86, 8'h0E, 4'h0, 2'b00, "R3");
      readback(4'h1, "R3 foreign");
      // R9 switchback keeps the slow bit
      step(1'b1, CA, 8'h0D, 4'h0, 2'b00, "R9");
      step(1'b0, CA, 8'h00, 4'h0, 2'b10, "R7");
      step(1'b0, CA, 8'h00, 4'h4, 2'b00, "R8");
      readback(4'hD, "R9 kept");
      check(clk_slow == 1'b1, "R9 return", {7'b0, clk_slow}, 8'h1);
      // R5 / R6 stop then wake
      step(1'b1, CA, 8'h02, 4'h0, 2'b00, "R5");
      step(1'b0, CA, 8'h00, 4'h0, 2'b00, "R5 hold");
      step(1'b0, CA, 8'h00, 4'h8, 2'b00, "R6 wake");
      readback(4'h0, "R6 cleared");
      // R6 priority over a simultaneous stop write
      step(1'b1, CA, 8'h03, 4'h1, 2'b00, "R6 prio");
      readback(4'h1, "R6 prio");

      for (int i = 0; i < 600; i++) begin
         logic       we;
         logic [7:0] a;
         logic [3:0] irq;
         we  = ($urandom % 3) == 0;
         a   = (($urandom % 4) != 0) ? CA : 8'($urandom);
         irq = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
         step(we, a, 8'($urandom), irq, 2'($urandom), "rand");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule